// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a window watchdog on a 32-bit register interface. A 7-bit down counter steps at a rate set by a prescaler running on the peripheral clock. Software turns the watchdog on by setting an activation bit. After that, the activation bit cannot be cleared except by a system reset. Once active, the block requests a system reset in three cases:
- the counter steps from 0x40 to 0x3F;
- software reloads the counter while its value is still above a programmable window value;
- software writes a counter value whose bit 6 is zero.

An early-warning flag is raised when the counter steps down to 0x40, one step before the timeout. That flag drives an interrupt when the interrupt is enabled.

The register port is a plain single-cycle write strobe with a byte address and a combinational read. The reset request leaves the block as a registered one-cycle pulse for the system reset controller. The interrupt output goes to the interrupt controller.

Top module: `win_wdog`

## Requirements
- R1: After rst_ni is released, every register reads 0, and wdog_rst_o and irq_o are 0.
- R2: The control register at byte offset 0x0 holds the counter in bits 6:0 and the activation bit in bit 7. A write loads the counter from bits 6:0. Bit 7 can be set by a write but never cleared by one.
- R3: The counter decrements once every 2^(BASE_LOG2+TB) clock cycles, where TB is the timer-base field. Every control write restarts the prescaler, so the first decrement comes exactly one full period after the write edge.
- R4: While active, the counter stepping from 0x40 to 0x3F raises wdog_rst_o on that same clock edge.
- R5: While active, a control write made when the counter is strictly greater than the window value raises wdog_rst_o. A write made when the counter is equal to or below the window value does not.
- R6: A control write whose bit 6 is 0 raises wdog_rst_o if the activation bit is already 1 or is set by that same write.
- R7: wdog_rst_o is registered and lasts exactly one cycle. It goes high on the clock edge that accepts the cause.
- R8: The configuration register at byte offset 0x4 holds the window value in bits 6:0, the interrupt enable in bit 9 and the timer-base field TB in bits 12:11. The interrupt enable can be set by a write but never cleared by one.
- R9: The status register at byte offset 0x8 holds the warning flag in bit 0. The flag is set when the counter decrements from 0x41 to 0x40, whatever the enable and activation bits are. Writing 0 to the flag clears it. Writing 1 leaves it unchanged.
- R10: irq_o equals the warning flag ANDed with the interrupt enable.
- R11: While the activation bit is 0, the counter keeps stepping, but neither a timeout nor a control write can raise wdog_rst_o, except a write that activates the watchdog with bit 6 equal to 0.
- R12: Register bits other than the listed fields read 0 and are not changed by writes. Unmapped addresses, such as 0xC, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| wdog_rst_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Early-warning interrupt |

## Verification
The assertions check these properties on every cycle:
- the activation bit and the interrupt enable never drop;
- the counter holds its value between prescaler ticks;
- every reset pulse lasts one cycle;
- an active 0x40 timeout always produces a pulse;
- an inactive watchdog with no write never produces one;
- a write of 1 to the status flag never clears it.

Some behaviour only the bench scenarios can show:
- the exact period for each timer base, and its restart on reload;
- the window boundary, where a counter equal to the window value is allowed;
- the bit-6 rule on writes;
- the warning flag being set while the watchdog is inactive;
- read masking of unused bits.

The bench covers these through directed sequences and a cycle-by-cycle reference model.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int CNT_W  = 7;
  localparam int DATA_W = 32;
  localparam int TB_W   = 2;

  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_CFG  = 4'h4;
  localparam logic [3:0] OFF_STAT = 4'h8;

  localparam int CTRL_ACT_BIT = 7;
  localparam int CFG_IE_BIT   = 9;
  localparam int CFG_TB_LSB   = 11;
  localparam int STAT_WF_BIT  = 0;

  localparam logic [CNT_W-1:0] WARN_VAL = 7'h40;
  localparam logic [CNT_W-1:0] PRE_WARN = 7'h41;
endpackage

// File: rtl/wdog_presc.sv
`timescale 1ns/1ps
module wdog_presc #(
  parameter int BASE_LOG2 = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic [wdog_pkg::TB_W-1:0] tb_i,
  output logic                   tick_o
);
  localparam int PW = BASE_LOG2 + 3;

  logic [PW-1:0] cnt_q;
  logic [PW:0]   lim_m1;

  assign lim_m1 = ((PW+1)'(1) << (BASE_LOG2 + int'(tb_i))) - (PW+1)'(1);
  // >= so a shrinking timer base ticks at once instead of wrapping
  assign tick_o = {1'b0, cnt_q} >= lim_m1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/wdog_cnt.sv
`timescale 1ns/1ps
module wdog_cnt
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             warn_hit_o,
  output logic             timeout_o
);
  logic step;
  assign step       = tick_i && !load_i;
  assign warn_hit_o = step && (cnt_o == PRE_WARN);
  assign timeout_o  = step && (cnt_o == WARN_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (tick_i) cnt_o <= cnt_o - CNT_W'(1);
  end

  // R3
  hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_o));
endmodule

// File: rtl/wdog_pulse.sv
`timescale 1ns/1ps
module wdog_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= req_i && !pulse_o;
  end

  // R7
  single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/win_wdog.sv
`timescale 1ns/1ps
module win_wdog
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdog_rst_o,
  output logic              irq_o
);
  logic             act_q, ie_q, wf_q;
  logic [CNT_W-1:0] win_q, cnt;
  logic [TB_W-1:0]  tb_q;
  logic             tick, warn_hit, timeout;
  logic             ctrl_wr, cfg_wr, stat_wr;
  logic             act_nxt, win_viol, b6_viol, bark_req;
  logic             unused_wdata;

  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign cfg_wr  = wr_en_i && (addr_i == ADDR_W'(OFF_CFG));
  assign stat_wr = wr_en_i && (addr_i == ADDR_W'(OFF_STAT));

  assign unused_wdata = ^{wdata_i[DATA_W-1:CFG_TB_LSB+TB_W], wdata_i[CFG_IE_BIT+1],
                          wdata_i[CFG_IE_BIT-1]};

  wdog_presc #(.BASE_LOG2(BASE_LOG2)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_wr),
    .tb_i   (tb_q),
    .tick_o (tick)
  );

  wdog_cnt u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctrl_wr),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .tick_i     (tick),
    .cnt_o      (cnt),
    .warn_hit_o (warn_hit),
    .timeout_o  (timeout)
  );

  assign act_nxt  = act_q | wdata_i[CTRL_ACT_BIT];
  assign win_viol = ctrl_wr && act_q && (cnt > win_q);
  assign b6_viol  = ctrl_wr && act_nxt && !wdata_i[CNT_W-1];
  assign bark_req = win_viol || b6_viol || (timeout && act_q);

  wdog_pulse u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (bark_req),
    .pulse_o (wdog_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      ie_q  <= 1'b0;
      win_q <= '0;
      tb_q  <= '0;
      wf_q  <= 1'b0;
    end else begin
      if (ctrl_wr) act_q <= act_nxt;
      if (cfg_wr) begin
        win_q <= wdata_i[CNT_W-1:0];
        ie_q  <= ie_q | wdata_i[CFG_IE_BIT];
        tb_q  <= wdata_i[CFG_TB_LSB +: TB_W];
      end
      // hardware set wins over a software clear in the same cycle
      if (warn_hit)                           wf_q <= 1'b1;
      else if (stat_wr && !wdata_i[STAT_WF_BIT]) wf_q <= 1'b0;
    end
  end

  assign irq_o = wf_q && ie_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CTRL)) begin
      rdata_o[CNT_W-1:0]   = cnt;
      rdata_o[CTRL_ACT_BIT] = act_q;
    end else if (addr_i == ADDR_W'(OFF_CFG)) begin
      rdata_o[CNT_W-1:0]            = win_q;
      rdata_o[CFG_IE_BIT]           = ie_q;
      rdata_o[CFG_TB_LSB +: TB_W]   = tb_q;
    end else if (addr_i == ADDR_W'(OFF_STAT)) begin
      rdata_o[STAT_WF_BIT] = wf_q;
    end
  end

  // R2
  act_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |=> act_q);
  // R8
  ie_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_q |=> ie_q);
  // R4
  timeout_bark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && tick && !ctrl_wr && cnt == WARN_VAL && !wdog_rst_o) |=> wdog_rst_o);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && !ctrl_wr) |=> !wdog_rst_o);
  // R9
  wf_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && wdata_i[STAT_WF_BIT] && wf_q) |=> wf_q);
  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie_q && wf_q));
endmodule

// File: tb/win_wdog_bench.sv
`timescale 1ns/1ps
module win_wdog_bench;
  localparam int BASE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_o, irq_o;

  int total = 0, fails = 0, cyc = 0, rst_cnt = 0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  win_wdog #(.BASE_LOG2(BASE), .ADDR_W(4)) u_win_wdog (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .wdog_rst_o(rst_o), .irq_o(irq_o)
  );

  // reference model
  logic [6:0] m_cnt, m_pre, m_w;
  logic       m_act, m_ie, m_wf, m_rst;
  logic [1:0] m_tb;

  always @(posedge clk or negedge rst_n) begin : model
    logic tk, rq, st;
    logic [7:0] lim;
    if (!rst_n) begin
      m_cnt <= 0; m_pre <= 0; m_w <= 0; m_act <= 0; m_ie <= 0;
      m_wf <= 0; m_rst <= 0; m_tb <= 0;
    end else begin
      lim = 8'(16 << m_tb) - 8'd1;
      tk = {1'b0, m_pre} >= lim;
      rq = 1'b0; st = 1'b0;
      if (we && addr == 4'h0) begin
        rq = (m_act && m_cnt > m_w) || ((m_act | wdata[7]) && !wdata[6]);
        m_act <= m_act | wdata[7];
        m_cnt <= wdata[6:0];
        m_pre <= 0;
      end else begin
        m_pre <= tk ? 7'd0 : m_pre + 7'd1;
        if (tk) begin
          m_cnt <= m_cnt - 7'd1;
          st = (m_cnt == 7'h41);
          rq = m_act && (m_cnt == 7'h40);
        end
      end
      if (we && addr == 4'h4) begin
        m_w <= wdata[6:0]; m_ie <= m_ie | wdata[9]; m_tb <= wdata[12:11];
      end
      if (st) m_wf <= 1'b1;
      else if (we && addr == 4'h8 && !wdata[0]) m_wf <= 1'b0;
      m_rst <= rq && !m_rst;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      4'h0:    return {24'h0, m_act, m_cnt};
      4'h4:    return {19'h0, m_tb, 1'b0, m_ie, 2'b00, m_w};
      4'h8:    return {31'h0, m_wf};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rst_o) rst_cnt++;
    if (rst_n && cmp_en) begin
      chk(addr == 4'h0 ? "R2" : addr == 4'h4 ? "R8" : addr == 4'h8 ? "R9" : "R12",
          rdata, exp_rd(addr));
      chk("R7", {31'h0, rst_o}, {31'h0, m_rst});
      chk("R10", {31'h0, irq_o}, {31'h0, m_wf && m_ie});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    chk(tag, rdata, e);
  endtask

  task automatic rst_chk(input int e, input string tag);
    repeat (2) @(negedge clk);
    chk(tag, rst_cnt, e);
  endtask

  int r0;
  int unsigned seed = 32'h5eed_1234;
  int unsigned sd;

  initial begin
    sd = $urandom(seed);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_en = 1'b1;
    // R1 reset state
    rd_chk(4'h0, 32'h0, "R1");
    rd_chk(4'h4, 32'h0, "R1");
    rd_chk(4'h8, 32'h0, "R1");
    chk("R1", {30'h0, rst_o, irq_o}, 32'h0);

    // R3 period with TB=0, R9 flag while inactive
    wr(4'h4, 32'h0000_007F);
    wr(4'h0, 32'h0000_0041);
    repeat (14) @(posedge clk);
    rd_chk(4'h0, 32'h41, "R3");
    rd_chk(4'h0, 32'h40, "R3");
    rd_chk(4'h8, 32'h1, "R9");
    chk("R10", {31'h0, irq_o}, 32'h0);
    wr(4'h8, 32'h1);
    rd_chk(4'h8, 32'h1, "R9");
    wr(4'h8, 32'h0);
    rd_chk(4'h8, 32'h0, "R9");
    // R11 inactive: timeout passes and bit-6-zero write, no pulse
    r0 = rst_cnt;
    repeat (40) @(posedge clk);
    wr(4'h0, 32'h0000_0010);
    rst_chk(r0, "R11");

    // R5 window violation
    wr(4'h4, 32'h0000_0250);
    wr(4'h0, 32'h0000_00FF);
    rst_chk(r0, "R5");
    wr(4'h0, 32'h0000_00FF);
    rst_chk(r0 + 1, "R5");
    // R6 bit-6 rule, R2 sticky activation
    wr(4'h4, 32'h0000_027F);
    wr(4'h0, 32'h0000_00B0);
    rst_chk(r0 + 2, "R6");
    rd_chk(4'h0, 32'hB0, "R2");
    wr(4'h0, 32'h0000_0000);
    rst_chk(r0 + 3, "R6");
    rd_chk(4'h0, 32'h80, "R2");
    // R4 timeout and R10 interrupt
    wr(4'h0, 32'h0000_00C1);
    repeat (18) @(posedge clk);
    @(negedge clk);
    chk("R10", {31'h0, irq_o}, 32'h1);
    chk("R4", rst_cnt, r0 + 3);
    repeat (16) @(posedge clk);
    rst_chk(r0 + 4, "R4");

    // R5 boundary: equal to window is allowed, one above is not
    wr(4'h4, 32'h0000_0050);
    rd_chk(4'h4, 32'h250, "R8");
    wr(4'h0, 32'h0000_00D0);
    wr(4'h0, 32'h0000_00D0);
    rst_chk(r0 + 4, "R5");
    wr(4'h0, 32'h0000_00D1);
    wr(4'h0, 32'h0000_00D1);
    rst_chk(r0 + 5, "R5");

    // R3 period with TB=2
    wr(4'h4, 32'h0000_107F);
    wr(4'h0, 32'h0000_00F0);
    repeat (62) @(posedge clk);
    rd_chk(4'h0, 32'hF0, "R3");
    rd_chk(4'h0, 32'hEF, "R3");

    // R12 unused bits and unmapped address
    wr(4'h4, 32'hFFFF_FFFF);
    rd_chk(4'h4, 32'h0000_1A7F, "R12");
    wr(4'hC, 32'hFFFF_FFFF);
    rd_chk(4'hC, 32'h0, "R12");
    wr(4'h8, 32'hFFFF_FFFE);
    rd_chk(4'h8, 32'h0, "R9");

    // random traffic against the model
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); #1;
      addr  = 4'($urandom % 4) << 2;
      wdata = $urandom;
      we    = ($urandom % 8) == 0;
    end
    @(posedge clk); #1 we = 1'b0;
    repeat (4) @(posedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule